// File: doc/BRIEF.md
# Two-Level Hardware Breakpoint Trigger

This block sits beside a processor core and watches two streams: the program counter of each instruction fetch, and the address and data of each data bus transfer. It compares them against programmable conditions and raises a request when they match. One request stops the core. The other is a debug interrupt request. The PC condition uses a value and a bit mask. The bus condition uses an inclusive address window and can also require a masked data match on the same bus cycle.

The two conditions can drive the trigger in one of two modes. In single-level mode, either enabled condition fires the trigger at once. In two-level mode, one chosen condition arms the unit, and the other chosen condition fires it on a later cycle.

A single register port loads and reads back the seven registers. Every access carries a supervisor flag. This port stands in for both the debug serial channel and privileged software access.

After a trigger fires, the unit turns itself off. Software must write the control register again to re-enable it.

Top module: `bkpt_trigger`

## Requirements
- R1: Accesses are honoured only while `regSuper` is 1. A write with `regSuper` = 1 stores `regWrData` into the register selected by `regAddr`. The map is: 0 window low, 1 window high, 2 data value, 3 data mask, 4 PC value, 5 PC mask, 6 control. A read shows that register on `regRdData`. A write with `regSuper` = 0 changes nothing. A read with `regSuper` = 0 returns zero. Address 7 reads as zero.
- R2: The PC condition is true when `fetchValid` is 1, control bit 6 (PC condition enable) is set, and `((fetchPc ^ pcValue) & pcMask) == 0`. A mask bit of 1 makes that PC bit take part in the comparison.
- R3: The bus condition requires `busValid` = 1, control bit 7 (bus condition enable) set, and `windowLow <= busAddr <= windowHigh`, with both bounds included.
- R4: When control bit 4 (data qualify) is set, the bus condition also requires `((busData ^ dataValue) & dataMask) == 0` in the same cycle as the address match. When bit 4 is clear, the data bus is ignored.
- R5: With control bit 0 (enable) set and bit 1 (two-level) clear, either true condition fires the trigger. The request appears in the cycle after the input cycle in which the condition matched.
- R6: With bit 1 set, the first-level condition arms the unit and does not fire it. Bit 2 selects the first-level condition and bit 3 selects the second-level condition; for each, 0 means PC and 1 means bus. The trigger fires only when the second-level condition is true in a cycle strictly after the arming cycle. A second-level match in the arming cycle itself does not fire.
- R7: A write to the control register clears the armed state. No trigger fires in the cycle of that write.
- R8: Control bit 5 selects the action: 0 pulses `haltReq`, 1 pulses `dbgIrqReq`. Each pulse lasts exactly one cycle, and the two outputs are never high together.
- R9: When the trigger fires, control bit 0 clears. Reads then show it as 0, and no further request is raised until software sets bit 0 again.
- R10: After reset, all seven registers read as zero and both request outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regSuper | input | 1 | Access is privileged (debug channel or supervisor) |
| regAddr | input | 3 | Register select |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| fetchValid | input | 1 | Instruction fetch this cycle |
| fetchPc | input | 32 | Fetch program counter |
| busValid | input | 1 | Data bus transfer this cycle |
| busAddr | input | 32 | Data bus address |
| busData | input | 32 | Data bus data |
| haltReq | output | 1 | One-cycle halt request |
| dbgIrqReq | output | 1 | One-cycle debug interrupt request |

## Verification
The hardest state to reach from the ports is an armed unit that then sees a control write while a second-level match is already on the bus. Only the later absence of a request shows that the armed state was dropped.

The bench reaches this state in three steps:
1. It arms the unit with a PC match.
2. It holds a matching bus transfer across a control-register write.
3. It keeps the transfer one more cycle and expects no request on either cycle.

The same-cycle case, where both levels match at once, is driven the same way: the first cycle must stay silent and the following bus-only cycle must fire.

// File: rtl/bkpt_pkg.sv
`timescale 1ns/1ps
package bkpt_pkg;
  localparam int unsigned REG_COUNT = 7;
  localparam int unsigned REG_AW    = $clog2(REG_COUNT + 1);

  localparam int unsigned RIDX_LO    = 0;
  localparam int unsigned RIDX_HI    = 1;
  localparam int unsigned RIDX_DATA  = 2;
  localparam int unsigned RIDX_DMASK = 3;
  localparam int unsigned RIDX_PC    = 4;
  localparam int unsigned RIDX_PMASK = 5;
  localparam int unsigned RIDX_CTRL  = 6;

  localparam int unsigned CB_ENABLE = 0;
  localparam int unsigned CB_TWOLVL = 1;
  localparam int unsigned CB_L1BUS  = 2;
  localparam int unsigned CB_L2BUS  = 3;
  localparam int unsigned CB_DQUAL  = 4;
  localparam int unsigned CB_IRQ    = 5;
  localparam int unsigned CB_PCEN   = 6;
  localparam int unsigned CB_BUSEN  = 7;

  typedef struct packed {
    logic enable;
    logic twoLevel;
    logic lvl1Bus;
    logic lvl2Bus;
    logic actIrq;
  } cfg_t;

  typedef struct packed {
    logic clrEnable;
  } strobe_t;
endpackage

// File: rtl/bkpt_datapath.sv
`timescale 1ns/1ps
module bkpt_datapath
  import bkpt_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic                 regSuper,
  input  logic [REG_AW-1:0]    regAddr,
  input  logic [DW-1:0]        regWrData,
  output logic [DW-1:0]        regRdData,
  input  logic                 fetchValid,
  input  logic [DW-1:0]        fetchPc,
  input  logic                 busValid,
  input  logic [DW-1:0]        busAddr,
  input  logic [DW-1:0]        busData,
  input  strobe_t              strobe,
  output cfg_t                 cfg,
  output logic                 pcHit,
  output logic                 busHit,
  output logic                 ctlWrite
);
  logic [DW-1:0] regs [REG_COUNT];
  logic          wrOk;
  logic          pcMatch;
  logic          inWindow;
  logic          dataOk;

  assign wrOk     = regWrEn & regSuper;
  assign ctlWrite = wrOk && (regAddr == REG_AW'(RIDX_CTRL));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < REG_COUNT; i++) regs[i] <= '0;
    end else begin
      for (int i = 0; i < REG_COUNT; i++)
        if (wrOk && regAddr == REG_AW'(i)) regs[i] <= regWrData;
      if (strobe.clrEnable && !ctlWrite) regs[RIDX_CTRL][CB_ENABLE] <= 1'b0;
    end
  end

  always_comb begin
    regRdData = '0;
    if (regSuper)
      for (int i = 0; i < REG_COUNT; i++)
        if (regAddr == REG_AW'(i)) regRdData = regs[i];
  end

  // masked PC compare: mask bit 1 = bit participates
  assign pcMatch  = ((fetchPc ^ regs[RIDX_PC]) & regs[RIDX_PMASK]) == '0;
  assign inWindow = (busAddr >= regs[RIDX_LO]) && (busAddr <= regs[RIDX_HI]);
  assign dataOk   = !regs[RIDX_CTRL][CB_DQUAL] ||
                    (((busData ^ regs[RIDX_DATA]) & regs[RIDX_DMASK]) == '0);

  assign pcHit  = regs[RIDX_CTRL][CB_PCEN] & fetchValid & pcMatch;
  assign busHit = regs[RIDX_CTRL][CB_BUSEN] & busValid & inWindow & dataOk;

  assign cfg.enable   = regs[RIDX_CTRL][CB_ENABLE];
  assign cfg.twoLevel = regs[RIDX_CTRL][CB_TWOLVL];
  assign cfg.lvl1Bus  = regs[RIDX_CTRL][CB_L1BUS];
  assign cfg.lvl2Bus  = regs[RIDX_CTRL][CB_L2BUS];
  assign cfg.actIrq   = regs[RIDX_CTRL][CB_IRQ];
endmodule

// File: rtl/bkpt_control.sv
`timescale 1ns/1ps
module bkpt_control
  import bkpt_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  cfg_t    cfg,
  input  logic    pcHit,
  input  logic    busHit,
  input  logic    ctlWrite,
  output strobe_t strobe,
  output logic    armed,
  output logic    haltReq,
  output logic    dbgIrqReq
);
  logic lvl1Hit;
  logic lvl2Hit;
  logic fire;

  assign lvl1Hit = cfg.lvl1Bus ? busHit : pcHit;
  assign lvl2Hit = cfg.lvl2Bus ? busHit : pcHit;

  always_comb begin
    fire = 1'b0;
    if (cfg.enable && !ctlWrite)
      fire = cfg.twoLevel ? (armed & lvl2Hit) : (pcHit | busHit);
  end

  assign strobe.clrEnable = fire;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed     <= 1'b0;
      haltReq   <= 1'b0;
      dbgIrqReq <= 1'b0;
    end else begin
      haltReq   <= fire & ~cfg.actIrq;
      dbgIrqReq <= fire &  cfg.actIrq;
      if (ctlWrite || fire)
        armed <= 1'b0;
      else if (cfg.enable && cfg.twoLevel && lvl1Hit)
        armed <= 1'b1;
    end
  end
endmodule

// File: rtl/bkpt_trigger.sv
`timescale 1ns/1ps
module bkpt_trigger
  import bkpt_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regSuper,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DW-1:0]     regWrData,
  output logic [DW-1:0]     regRdData,
  input  logic              fetchValid,
  input  logic [DW-1:0]     fetchPc,
  input  logic              busValid,
  input  logic [DW-1:0]     busAddr,
  input  logic [DW-1:0]     busData,
  output logic              haltReq,
  output logic              dbgIrqReq
);
  cfg_t    cfg;
  strobe_t strobe;
  logic    pcHit;
  logic    busHit;
  logic    ctlWrite;
  logic    armed;

  bkpt_datapath #(.DW(DW)) i_datapath (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regSuper(regSuper), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .fetchValid(fetchValid), .fetchPc(fetchPc),
    .busValid(busValid), .busAddr(busAddr), .busData(busData),
    .strobe(strobe), .cfg(cfg),
    .pcHit(pcHit), .busHit(busHit), .ctlWrite(ctlWrite)
  );

  bkpt_control i_control (
    .clk(clk), .rstN(rstN),
    .cfg(cfg), .pcHit(pcHit), .busHit(busHit), .ctlWrite(ctlWrite),
    .strobe(strobe), .armed(armed),
    .haltReq(haltReq), .dbgIrqReq(dbgIrqReq)
  );
endmodule

// File: rtl/bkpt_trigger_chk.sv
`timescale 1ns/1ps
module bkpt_trigger_chk (
  input logic clk,
  input logic rstN,
  input logic haltReq,
  input logic dbgIrqReq,
  input logic armed,
  input logic cfgEnable,
  input logic cfgTwoLevel,
  input logic ctlWrite
);
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    !(haltReq && dbgIrqReq)); // R8

  AST_HALT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    haltReq |=> !haltReq); // R8

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    dbgIrqReq |=> !dbgIrqReq); // R8

  AST_SELF_DISABLE: assert property (@(posedge clk) disable iff (!rstN)
    (haltReq || dbgIrqReq) |-> !cfgEnable); // R9

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnable |=> !(haltReq || dbgIrqReq)); // R9

  AST_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rstN)
    (cfgTwoLevel && !armed) |=> !(haltReq || dbgIrqReq)); // R6

  AST_WRITE_DISARMS: assert property (@(posedge clk) disable iff (!rstN)
    ctlWrite |=> (!armed && !haltReq && !dbgIrqReq)); // R7
endmodule

bind bkpt_trigger bkpt_trigger_chk i_chk (
  .clk(clk), .rstN(rstN),
  .haltReq(haltReq), .dbgIrqReq(dbgIrqReq),
  .armed(armed), .cfgEnable(cfg.enable), .cfgTwoLevel(cfg.twoLevel),
  .ctlWrite(ctlWrite)
);

// File: tb/test_bkpt_trigger.sv
`timescale 1ns/1ps
module test_bkpt_trigger;
  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn, regSuper;
  logic [2:0]  regAddr;
  logic [31:0] regWrData, regRdData;
  logic        fetchValid, busValid;
  logic [31:0] fetchPc, busAddr, busData;
  logic        haltReq, dbgIrqReq;
  int          checks = 0;
  int          errors = 0;

  always #2 clk = ~clk;

  bkpt_trigger i_bkpt_trigger (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSuper(regSuper),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .fetchValid(fetchValid), .fetchPc(fetchPc), .busValid(busValid),
    .busAddr(busAddr), .busData(busData),
    .haltReq(haltReq), .dbgIrqReq(dbgIrqReq)
  );

  function automatic logic [31:0] ctl(input bit en, two, l1bus, l2bus,
                                      dq, irq, pcen, busen);
    return {24'h0, busen, pcen, irq, dq, l2bus, l1bus, two, en};
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic s);
    regAddr = a; regWrData = d; regSuper = s; regWrEn = 1'b1;
    step();
    regWrEn = 1'b0; regSuper = 1'b1;
  endtask

  task automatic rd(input logic [2:0] a, input logic s, input logic [31:0] exp, input string tag);
    regAddr = a; regSuper = s;
    #1;
    chk(regRdData, exp, tag);
    regSuper = 1'b1;
  endtask

  task automatic idle();
    fetchValid = 1'b0; busValid = 1'b0;
  endtask

  // program control, apply one input cycle, check request, then check pulse end
  task automatic shot(input logic [31:0] c, input logic fv, input logic [31:0] pc,
                      input logic bv, input logic [31:0] ad, input logic [31:0] dt,
                      input logic expH, input logic expI, input string tag);
    wr(3'd6, c, 1'b1);
    fetchValid = fv; fetchPc = pc; busValid = bv; busAddr = ad; busData = dt;
    step();
    chk({31'h0, haltReq}, {31'h0, expH}, tag);
    chk({31'h0, dbgIrqReq}, {31'h0, expI}, tag);
    idle();
    step();
    chk({30'h0, haltReq, dbgIrqReq}, 32'h0, {tag, " pulse end R8"});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] cP, cB, cD, c2, c3;
    rstN = 1'b0; regWrEn = 1'b0; regSuper = 1'b1; regAddr = '0; regWrData = '0;
    fetchValid = 1'b0; busValid = 1'b0; fetchPc = '0; busAddr = '0; busData = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R10 reset state
    for (int i = 0; i < 7; i++) rd(3'(i), 1'b1, 32'h0, "R10 reg reset");
    chk({30'h0, haltReq, dbgIrqReq}, 32'h0, "R10 outputs low");

    // R1 register access
    for (int i = 0; i < 6; i++) wr(3'(i), 32'h1111_1111 * (i + 1), 1'b1);
    wr(3'd6, 32'h0000_A51E, 1'b1);
    for (int i = 0; i < 6; i++) rd(3'(i), 1'b1, 32'h1111_1111 * (i + 1), "R1 readback");
    rd(3'd6, 1'b1, 32'h0000_A51E, "R1 control readback");
    wr(3'd0, 32'hDEAD_BEEF, 1'b0);
    rd(3'd0, 1'b1, 32'h1111_1111, "R1 unprivileged write ignored");
    rd(3'd2, 1'b0, 32'h0, "R1 unprivileged read zero");
    wr(3'd7, 32'hFFFF_FFFF, 1'b1);
    rd(3'd7, 1'b1, 32'h0, "R1 address 7 reads zero");
    wr(3'd6, 32'h0, 1'b1);

    cP = ctl(1,0,0,0,0,0,1,0);
    cB = ctl(1,0,0,0,0,0,0,1);
    cD = ctl(1,0,0,0,1,0,0,1);

    // R2 masked PC sweep, two masks
    wr(3'd4, 32'h1000_0040, 1'b1);
    for (int m = 0; m < 2; m++) begin
      logic [31:0] mask;
      mask = (m == 0) ? 32'hFFFF_FFF0 : 32'hFFFF_FFCF;
      wr(3'd5, mask, 1'b1);
      for (int i = 0; i < 32; i++) begin
        logic [31:0] pc;
        logic fv, exp;
        pc = 32'h1000_0030 + 32'(i);
        fv = (i != 20);
        exp = fv && (((pc ^ 32'h1000_0040) & mask) == 0);
        shot(cP, fv, pc, 1'b0, 32'h0, 32'h0, exp, 1'b0, "R2 pc sweep R5");
      end
    end
    wr(3'd5, 32'hFFFF_FFFF, 1'b1);
    shot(ctl(1,0,0,0,0,0,0,0), 1'b1, 32'h1000_0040, 1'b0, 0, 0, 1'b0, 1'b0, "R2 pc enable off");

    // R3 inclusive address window sweep
    wr(3'd0, 32'h0000_0200, 1'b1);
    wr(3'd1, 32'h0000_020F, 1'b1);
    for (int i = 0; i < 24; i++) begin
      logic [31:0] a;
      a = 32'h1FC + 32'(i);
      shot(cB, 1'b0, 0, 1'b1, a, 32'h5555_5555,
           (a >= 32'h200 && a <= 32'h20F), 1'b0, "R3 window sweep");
    end
    shot(cB, 1'b0, 0, 1'b0, 32'h205, 0, 1'b0, 1'b0, "R3 busValid low");
    wr(3'd0, 32'h300, 1'b1);
    wr(3'd1, 32'h300, 1'b1);
    for (int i = 0; i < 3; i++)
      shot(cB, 1'b0, 0, 1'b1, 32'h2FF + 32'(i), 0, (i == 1), 1'b0, "R3 single-point window");
    wr(3'd0, 32'h200, 1'b1);
    wr(3'd1, 32'h20F, 1'b1);

    // R4 data qualification
    wr(3'd2, 32'h0000_00A5, 1'b1);
    wr(3'd3, 32'h0000_00FF, 1'b1);
    for (int i = 0; i < 16; i++) begin
      logic [31:0] d;
      d = (32'(i) << 20) | ((i % 4 == 0) ? 32'hA5 : (32'hA0 + 32'(i)));
      shot(cD, 1'b0, 0, 1'b1, 32'h205, d,
           (((d ^ 32'hA5) & 32'hFF) == 0), 1'b0, "R4 data sweep");
    end
    shot(cD, 1'b0, 0, 1'b1, 32'h100, 32'hA5, 1'b0, 1'b0, "R4 data hit outside window");
    shot(cB, 1'b0, 0, 1'b1, 32'h205, 32'h0, 1'b1, 1'b0, "R4 data ignored when off");

    // R8 interrupt action
    shot(ctl(1,0,0,0,0,1,1,0), 1'b1, 32'h1000_0040, 1'b0, 0, 0, 1'b0, 1'b1, "R8 irq action");

    // R9 self-disable
    shot(cP, 1'b1, 32'h1000_0040, 1'b0, 0, 0, 1'b1, 1'b0, "R9 first fire");
    rd(3'd6, 1'b1, cP & ~32'h1, "R9 enable bit cleared");
    fetchValid = 1'b1; fetchPc = 32'h1000_0040;
    step();
    step();
    chk({30'h0, haltReq, dbgIrqReq}, 32'h0, "R9 no refire while disabled");
    idle();
    step();

    // R6 two-level: PC arms, bus fires
    c2 = ctl(1,1,0,1,0,0,1,1);
    wr(3'd6, c2, 1'b1);
    fetchValid = 1'b1; busValid = 1'b1; busAddr = 32'h205;
    step();
    chk({30'h0, haltReq, dbgIrqReq}, 32'h0, "R6 same-cycle levels do not fire");
    idle();
    step();
    chk({30'h0, haltReq, dbgIrqReq}, 32'h0, "R6 idle while armed");
    busValid = 1'b1;
    step();
    chk({31'h0, haltReq}, 32'h1, "R6 second level fires");
    idle();
    step();

    wr(3'd6, c2, 1'b1);
    busValid = 1'b1;
    step();
    chk({31'h0, haltReq}, 32'h0, "R6 second level before arm");
    busValid = 1'b0; fetchValid = 1'b1;
    step();
    chk({31'h0, haltReq}, 32'h0, "R6 arming cycle silent");
    fetchValid = 1'b0; busValid = 1'b1;
    step();
    chk({31'h0, haltReq}, 32'h1, "R6 fires after arm");
    idle();
    step();

    // R6 reversed order with interrupt action
    c3 = ctl(1,1,1,0,0,1,1,1);
    wr(3'd6, c3, 1'b1);
    busValid = 1'b1;
    step();
    chk({30'h0, haltReq, dbgIrqReq}, 32'h0, "R6 bus arms");
    busValid = 1'b0; fetchValid = 1'b1;
    step();
    chk({30'h0, haltReq, dbgIrqReq}, 32'h1, "R6 pc fires irq R8");
    idle();
    step();

    // R7 control write disarms
    wr(3'd6, c2, 1'b1);
    fetchValid = 1'b1;
    step();
    fetchValid = 1'b0; busValid = 1'b1;
    wr(3'd6, c2, 1'b1);
    chk({30'h0, haltReq, dbgIrqReq}, 32'h0, "R7 no fire on write cycle");
    step();
    chk({30'h0, haltReq, dbgIrqReq}, 32'h0, "R7 armed state cleared");
    idle();
    step();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule